// File: doc/BRIEF.md
# Three-Operand Register ALU Datapath

This block is a small clocked datapath built around four 8-bit registers. Three of them are operand registers (A, B, C) and one holds the result (Y). A combinational ALU reads the operand registers. Its output can be captured into the result register. The result register can in turn be copied back into any operand register, so computations can be chained.

On each clock edge, a 2-bit register pointer names one register as the target. A 2-bit action code then says what that target does: hold, load the external data word, load the result register, or (for the result register) capture the ALU output. A 3-bit operation code picks the ALU function. The block has no multi-cycle sequencing. Its only state is the register contents, and each edge applies one action to one register. The "states" of the design are therefore the register-file actions. They are named HOLD, LOAD_EXT, LOAD_RES and CAPTURE_ALU, and the pointer and action code choose which one applies on a given edge.

Top module: `tri_alu_dp`

## Requirements
- R1: A synchronous active-high reset clears all four registers to 0 on the next rising edge.
- R2: The register pointer selects the target: 00 is operand A, 01 is operand B, 10 is operand C and 11 is result Y. Every register that is not selected keeps its value.
- R3: When an operand register is the target, action 01 loads the external data word on the edge.
- R4: When an operand register is the target, action 10 loads the value Y held before the edge.
- R5: When an operand register is the target, actions 00 and 11 leave it unchanged.
- R6: When Y is the target, action 00 holds Y, and actions 01, 10 and 11 load the ALU output.
- R7: Op 000 gives A+B and op 001 gives A+B+C. Both sums wrap modulo 256.
- R8: Op 010 gives the bitwise complement of A, and op 011 gives A+1 modulo 256.
- R9: Op 100 rotates A right by one, so bit 0 moves to bit 7. Op 101 rotates A left by one, so bit 7 moves to bit 0.
- R10: Op 110 gives the bitwise NAND of A and B, and op 111 gives the bitwise NOR of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_data | input | 8 | External data word |
| reg_ptr | input | 2 | Target register pointer |
| act_code | input | 2 | Action applied to the target register |
| op_code | input | 3 | ALU operation select |
| opa_q | output | 8 | Operand A register |
| opb_q | output | 8 | Operand B register |
| opc_q | output | 8 | Operand C register |
| res_q | output | 8 | Result register |

## Verification
All four registers are visible at the ports. A wrong load, a missed hold or a write to the wrong register therefore shows up on the outputs one cycle after the edge where it happens. An ALU error stays hidden until a capture into Y. It then appears in res_q in the next cycle, and it spreads to operand registers if Y is loaded back into them. For this reason the bench captures into Y after every operation it sets up, and compares all four registers against a model after every edge.

// File: rtl/tri_alu_pkg.sv
package tri_alu_pkg;
    typedef enum logic [1:0] {
        PTR_A = 2'b00,
        PTR_B = 2'b01,
        PTR_C = 2'b10,
        PTR_Y = 2'b11
    } reg_ptr_e;

    typedef enum logic [1:0] {
        ACT_HOLD0 = 2'b00,
        ACT_EXT   = 2'b01,
        ACT_RES   = 2'b10,
        ACT_HOLD3 = 2'b11
    } act_e;

    typedef enum logic [2:0] {
        OP_ADD2 = 3'b000,
        OP_ADD3 = 3'b001,
        OP_INV  = 3'b010,
        OP_INC  = 3'b011,
        OP_ROR  = 3'b100,
        OP_ROL  = 3'b101,
        OP_NAND = 3'b110,
        OP_NOR  = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_LOAD_EXT,
        ST_LOAD_RES,
        ST_CAPTURE_ALU
    } reg_action_e;
endpackage

// File: rtl/tri_alu_core.sv
module tri_alu_core
    import tri_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [2:0]   op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op_e'(op))
            OP_ADD2: y = a + b;
            OP_ADD3: y = a + b + c;
            OP_INV:  y = ~a;
            OP_INC:  y = a + W'(1);
            OP_ROR:  y = {a[0], a[W-1:1]};
            OP_ROL:  y = {a[W-2:0], a[W-1]};
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

    // R9
    always_comb begin
        if (op == 3'b100) ror_wrap_chk: assert (y[W-1] == a[0]);
        if (op == 3'b101) rol_wrap_chk: assert (y[0] == a[W-1]);
    end
endmodule

// File: rtl/tri_alu_slot.sv
module tri_alu_slot
    import tri_alu_pkg::*;
#(
    parameter int W = 8,
    parameter bit IS_RESULT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic [1:0]   act,
    input  logic [W-1:0] ext_d,
    input  logic [W-1:0] res_d,
    input  logic [W-1:0] alu_d,
    output logic [W-1:0] q
);
    reg_action_e nxt_act;
    logic [W-1:0] nxt_q;

    always_comb begin
        nxt_act = ST_HOLD;
        if (sel) begin
            if (IS_RESULT) begin
                nxt_act = (act == 2'b00) ? ST_HOLD : ST_CAPTURE_ALU;
            end else begin
                unique case (act_e'(act))
                    ACT_EXT: nxt_act = ST_LOAD_EXT;
                    ACT_RES: nxt_act = ST_LOAD_RES;
                    default: nxt_act = ST_HOLD;
                endcase
            end
        end
    end

    always_comb begin
        unique case (nxt_act)
            ST_LOAD_EXT:    nxt_q = ext_d;
            ST_LOAD_RES:    nxt_q = res_d;
            ST_CAPTURE_ALU: nxt_q = alu_d;
            default:        nxt_q = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));
    // R2
    unsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(q));
endmodule

// File: rtl/tri_alu_dp.sv
module tri_alu_dp
    import tri_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ext_data,
    input  logic [1:0]   reg_ptr,
    input  logic [1:0]   act_code,
    input  logic [2:0]   op_code,
    output logic [W-1:0] opa_q,
    output logic [W-1:0] opb_q,
    output logic [W-1:0] opc_q,
    output logic [W-1:0] res_q
);
    localparam int NREG = 4;

    logic [W-1:0] alu_y;
    logic [W-1:0] q_arr [NREG];

    tri_alu_core #(.W(W)) u_core (
        .a(q_arr[0]), .b(q_arr[1]), .c(q_arr[2]), .op(op_code), .y(alu_y)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        tri_alu_slot #(.W(W), .IS_RESULT(i == NREG - 1)) u_slot (
            .clk(clk), .rst(rst),
            .sel(reg_ptr == 2'(i)),
            .act(act_code),
            .ext_d(ext_data),
            .res_d(q_arr[NREG-1]),
            .alu_d(alu_y),
            .q(q_arr[i])
        );
    end

    assign opa_q = q_arr[0];
    assign opb_q = q_arr[1];
    assign opc_q = q_arr[2];
    assign res_q = q_arr[3];

    // R3
    ext_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_ptr == 2'b00 && act_code == 2'b01) |=> (opa_q == $past(ext_data)));
    // R4
    res_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_ptr == 2'b01 && act_code == 2'b10) |=> (opb_q == $past(res_q)));
    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_ptr == 2'b11 && act_code != 2'b00) |=> (res_q == $past(alu_y)));
    // R7
    add3_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_ptr == 2'b11 && act_code == 2'b11 && op_code == 3'b001)
        |=> (res_q == W'($past(opa_q) + $past(opb_q) + $past(opc_q))));
endmodule

// File: tb/tri_alu_dp_tb.sv
module tri_alu_dp_tb;
    logic clk = 0;
    logic rst;
    logic [7:0] ext_data;
    logic [1:0] reg_ptr, act_code;
    logic [2:0] op_code;
    logic [7:0] opa_q, opb_q, opc_q, res_q;
    int n_run = 0, n_fail = 0;
    logic [7:0] ma, mb, mc, my;

    always #2 clk = ~clk;

    tri_alu_dp u_dut (.*);

    function automatic logic [7:0] ref_alu(input logic [2:0] op,
        input logic [7:0] a, b, c);
        case (op)
            3'd0: return a + b;
            3'd1: return a + b + c;
            3'd2: return ~a;
            3'd3: return a + 8'd1;
            3'd4: return {a[0], a[7:1]};
            3'd5: return {a[6:0], a[7]};
            3'd6: return ~(a & b);
            default: return ~(a | b);
        endcase
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] p, input logic [1:0] f,
        input logic [2:0] op, input logic [7:0] d, input string rq);
        logic [7:0] ya;
        reg_ptr = p; act_code = f; op_code = op; ext_data = d;
        ya = ref_alu(op, ma, mb, mc);
        @(posedge clk);
        case (p)
            2'd0: if (f == 2'd1) ma = d; else if (f == 2'd2) ma = my;
            2'd1: if (f == 2'd1) mb = d; else if (f == 2'd2) mb = my;
            2'd2: if (f == 2'd1) mc = d; else if (f == 2'd2) mc = my;
            default: if (f != 2'd0) my = ya;
        endcase
        #1;
        chk({rq, " A"}, opa_q, ma);
        chk({rq, " B"}, opb_q, mb);
        chk({rq, " C"}, opc_q, mc);
        chk({rq, " Y"}, res_q, my);
    endtask

    initial begin
        #40000;
        n_fail++; n_run++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int s;
        s = $urandom(7);
        rst = 1; reg_ptr = 0; act_code = 0; op_code = 0; ext_data = 8'hAA;
        @(posedge clk); #1;
        ma = 0; mb = 0; mc = 0; my = 0;
        chk("R1 A", opa_q, 0); chk("R1 Y", res_q, 0);
        rst = 0;
        // directed corners
        step(0, 1, 0, 8'hF0, "R3");
        step(1, 1, 0, 8'h20, "R3");
        step(2, 1, 0, 8'h33, "R3");
        step(3, 1, 3'd0, 8'h00, "R7 add");       // F0+20 wraps to 10
        step(3, 2, 3'd1, 8'h00, "R7 addall");
        step(3, 0, 3'd2, 8'h00, "R6 hold");
        step(0, 0, 0, 8'h55, "R5 hold00");
        step(0, 3, 0, 8'h55, "R5 hold11");
        step(1, 2, 0, 8'h00, "R4");
        step(0, 1, 0, 8'h81, "R3");
        step(3, 3, 3'd4, 0, "R9 ror");
        step(3, 3, 3'd5, 0, "R9 rol");
        step(3, 1, 3'd2, 0, "R8 inv");
        step(0, 1, 0, 8'hFF, "R3");
        step(3, 1, 3'd3, 0, "R8 inc wrap");
        step(3, 1, 3'd6, 0, "R10 nand");
        step(3, 1, 3'd7, 0, "R10 nor");
        step(2, 2, 0, 0, "R4");
        // random
        for (int i = 0; i < 400; i++)
            step(2'($urandom), 2'($urandom), 3'($urandom), 8'($urandom), "R2 rand");
        rst = 1; step(3, 0, 0, 0, "R1 mid");
        rst = 0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // model update for reset inside step
    always @(posedge clk) if (rst) begin ma <= 0; mb <= 0; mc <= 0; my <= 0; end
endmodule